// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-State Monitor

This block watches a DDR2 command bus and follows the power state of the attached memory device. It sees the clock-enable pin, the four command strobes, the bank address, address bit 10 and address bits 9:7. From these it decodes each command, keeps a bitmap of open banks, and tracks a few recent operations that block power-state changes. On every rising clock edge it compares the clock-enable level at that edge with the level at the edge before. That pair decides whether the device stays where it is, enters power-down or self refresh, or leaves one of them.

The monitor reports the tracked state on a 3-bit output. Each protocol violation sets its own bit in a sticky error vector, and only a synchronous reset clears that vector. The window after self-refresh exit is timed in clock edges by a parameter for commands other than NOP and by a second parameter for READ. A monitor like this is placed beside a memory controller, in simulation or in silicon, to catch misuse of power management.

Top module: `cke_power_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at an edge) puts the tracker in the all-banks-idle state and clears every error bit. State codes: 0 idle, 1 bank-active, 2 precharge power-down, 3 active power-down, 4 self refresh, 5 self-refresh exit window.
- R2: In power-down (2, 3) or self refresh (4), an edge with clock-enable low at both the previous and the current edge keeps the state. Any command at such an edge is ignored and does not change the bank bitmap.
- R3: From power-down, clock-enable going low to high returns the tracker to normal operation. It reports state 1 if any bank is open and state 0 otherwise.
- R4: Commands decode from {csN,rasN,casN,weN} as follows: csN high is DESELECT, 0111 is NOP, 0001 is REFRESH, 0011 is ACTIVATE, 0010 is PRECHARGE, 0101 is READ, 0100 is WRITE, 0000 is mode-register set. These commands act only at edges where clock-enable is high at both edges. ACTIVATE opens bank `ba`. PRECHARGE closes bank `ba`, or closes every bank when `apBit` is 1. When clock-enable falls with NOP or DESELECT, the tracker enters state 3 if any bank is open and state 2 if none is open.
- R5: When clock-enable falls with REFRESH, the tracker enters self refresh (4). When clock-enable then rises, it enters the exit window (5). The window's first counted edge is the edge after the exit edge.
- R6: At an entry edge or exit edge of power-down or self refresh, any command other than NOP or DESELECT sets error bit 1.
- R7: An entry edge sets error bit 2 when fewer than OP_BUSY edges have passed since the last READ, WRITE, mode-register set, PRECHARGE or REFRESH. It also sets bit 2 when self refresh is entered with a bank open.
- R8: In the exit window, any command other than NOP or DESELECT at counted edges 1 to TXSNR sets error bit 3.
- R9: In the exit window, a READ before counted edge TXSRD (default 200) sets error bit 4. At edge TXSRD the tracker returns to normal operation, and a READ at that edge is legal.
- R10: A mode-register set with `ba`=1 turns calibration mode on if any bit of `ocdField` (address 9:7) is 1, and off otherwise. Clock-enable falling from normal operation while calibration is on sets error bit 5.
- R11: Clock-enable falling during the exit window sets error bit 0 and moves the tracker to power-down (3 if any bank is open, otherwise 2).
- R12: Error bits are sticky. Once set, a bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level at this edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| apBit | input | 1 | Address bit 10: precharge all banks |
| ocdField | input | 3 | Address bits 9:7 of a mode-register set |
| pwrState | output | 3 | Tracked power state (codes in R1) |
| errFlags | output | 6 | Sticky error bits (bit positions in R6 to R11) |

## Verification
Inside the self-refresh exit window, both the non-NOP check and the early-READ check apply at the same time. A READ issued at counted edge 3 violates both. The bench issues that READ and expects bits 3 and 4 together. It also probes each window alone at its boundary: an ACTIVATE just inside and just outside TXSNR, and a READ at edge TXSRD−1 and at edge TXSRD. These confirm that each check keeps to its own edge range. An entry edge is also driven while an operation is still busy and calibration mode is on, and the bench judges each of those error bits separately.

// File: rtl/ckemon_pkg.sv
package ckemon_pkg;

  localparam int NUM_ERR = 6;
  localparam int ERR_CKE   = 0;
  localparam int ERR_CMD   = 1;
  localparam int ERR_ENTRY = 2;
  localparam int ERR_XSNR  = 3;
  localparam int ERR_XSRD  = 4;
  localparam int ERR_OCD   = 5;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_REF, CMD_ACT, CMD_PRE,
    CMD_RD, CMD_WR, CMD_MRS, CMD_RSVD
  } cmd_e;

  // PS_IDLE doubles as the "normal operation" mode inside the control
  typedef enum logic [2:0] {
    PS_IDLE = 3'd0, PS_ACTIVE = 3'd1, PS_PPD = 3'd2,
    PS_APD = 3'd3, PS_SREF = 3'd4, PS_SRX = 3'd5
  } pwr_e;

  typedef struct packed {
    logic               exec;      // apply the command to bank/mode state
    logic               loadExit;  // start the exit-window count
    logic               incExit;   // advance the exit-window count
    logic [NUM_ERR-1:0] errSet;    // error bits raised this edge
  } strobe_t;

  function automatic cmd_e decodeCmd(input logic [3:0] pins);
    if (pins[3]) return CMD_DESEL;
    case (pins[2:0])
      3'b111:  return CMD_NOP;
      3'b001:  return CMD_REF;
      3'b011:  return CMD_ACT;
      3'b010:  return CMD_PRE;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b000:  return CMD_MRS;
      default: return CMD_RSVD;
    endcase
  endfunction

endpackage

// File: rtl/ckemon_dp.sv
module ckemon_dp
  import ckemon_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int TXSRD   = 200,
  parameter int OP_BUSY = 4,
  localparam int NUM_BANKS = 1 << BA_W,
  localparam int EXIT_W    = $clog2(TXSRD + 1),
  localparam int BUSY_W    = $clog2(OP_BUSY + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke,
  input  logic [3:0]         cmdPins,
  input  logic [BA_W-1:0]    ba,
  input  logic               apBit,
  input  logic [2:0]         ocdField,
  input  strobe_t            stb,
  output cmd_e               cmd,
  output logic               ckePrev,
  output logic               anyOpen,
  output logic               busy,
  output logic               ocdOn,
  output logic [EXIT_W-1:0]  exitCnt,
  output logic [NUM_ERR-1:0] errFlags
);

  logic [NUM_BANKS-1:0] openMap;
  logic [BUSY_W-1:0]    busyCnt;
  logic                 busyCmd;

  assign cmd     = decodeCmd(cmdPins);
  assign anyOpen = |openMap;
  assign busy    = (busyCnt != '0);
  assign busyCmd = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_MRS) ||
                   (cmd == CMD_PRE) || (cmd == CMD_REF);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        openMap[b] <= 1'b0;
      end else if (stb.exec) begin
        if (cmd == CMD_ACT && ba == BA_W'(b))
          openMap[b] <= 1'b1;
        else if (cmd == CMD_PRE && (apBit || ba == BA_W'(b)))
          openMap[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ckePrev  <= 1'b1;
      busyCnt  <= '0;
      ocdOn    <= 1'b0;
      exitCnt  <= '0;
      errFlags <= '0;
    end else begin
      ckePrev  <= cke;
      errFlags <= errFlags | stb.errSet;
      if (stb.exec && busyCmd)
        busyCnt <= BUSY_W'(OP_BUSY);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
      if (stb.exec && cmd == CMD_MRS && ba == BA_W'(1))
        ocdOn <= |ocdField;
      if (stb.loadExit)
        exitCnt <= EXIT_W'(1);
      else if (stb.incExit)
        exitCnt <= exitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ckemon_ctrl.sv
module ckemon_ctrl
  import ckemon_pkg::*;
#(
  parameter int TXSNR = 16,
  parameter int TXSRD = 200,
  localparam int EXIT_W = $clog2(TXSRD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              ckePrev,
  input  cmd_e              cmd,
  input  logic              anyOpen,
  input  logic              busy,
  input  logic              ocdOn,
  input  logic [EXIT_W-1:0] exitCnt,
  output strobe_t           stb,
  output pwr_e              pwrState
);

  pwr_e mode, modeNext;
  logic quiet;
  pwr_e pdTarget;

  assign quiet    = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign pdTarget = anyOpen ? PS_APD : PS_PPD;

  always_comb begin
    modeNext = mode;
    stb      = '0;
    case (mode)
      PS_IDLE: begin
        if (ckePrev && cke) begin
          stb.exec = 1'b1;
        end else if (ckePrev && !cke) begin
          if (ocdOn) stb.errSet[ERR_OCD] = 1'b1;
          if (cmd == CMD_REF) begin
            modeNext = PS_SREF;
            if (anyOpen || busy) stb.errSet[ERR_ENTRY] = 1'b1;
          end else begin
            modeNext = pdTarget;
            if (busy)   stb.errSet[ERR_ENTRY] = 1'b1;
            if (!quiet) stb.errSet[ERR_CMD]   = 1'b1;
          end
        end else begin
          stb.errSet[ERR_CKE] = 1'b1;
        end
      end
      PS_PPD, PS_APD, PS_SREF: begin
        if (ckePrev) begin
          stb.errSet[ERR_CKE] = 1'b1;
        end else if (cke) begin
          modeNext = (mode == PS_SREF) ? PS_SRX : PS_IDLE;
          stb.loadExit = (mode == PS_SREF);
          if (!quiet) stb.errSet[ERR_CMD] = 1'b1;
        end
      end
      PS_SRX: begin
        if (!cke) begin
          stb.errSet[ERR_CKE] = 1'b1;
          modeNext = pdTarget;
        end else begin
          stb.exec = 1'b1;
          if (!quiet && exitCnt <= EXIT_W'(TXSNR))
            stb.errSet[ERR_XSNR] = 1'b1;
          if (cmd == CMD_RD && exitCnt < EXIT_W'(TXSRD))
            stb.errSet[ERR_XSRD] = 1'b1;
          if (exitCnt >= EXIT_W'(TXSRD)) modeNext = PS_IDLE;
          else                           stb.incExit = 1'b1;
        end
      end
      default: modeNext = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= PS_IDLE;
    else     mode <= modeNext;
  end

  assign pwrState = (mode == PS_IDLE) ? (anyOpen ? PS_ACTIVE : PS_IDLE) : mode;

endmodule

// File: rtl/cke_power_monitor.sv
module cke_power_monitor
  import ckemon_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int TXSNR   = 16,
  parameter int TXSRD   = 200,
  parameter int OP_BUSY = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [BA_W-1:0] ba,
  input  logic            apBit,
  input  logic [2:0]      ocdField,
  output logic [2:0]      pwrState,
  output logic [5:0]      errFlags
);

  localparam int EXIT_W = $clog2(TXSRD + 1);

  strobe_t           stb;
  cmd_e              cmd;
  logic              ckePrev, anyOpen, busy, ocdOn;
  logic [EXIT_W-1:0] exitCnt;
  pwr_e              ps;

  ckemon_dp #(.BA_W(BA_W), .TXSRD(TXSRD), .OP_BUSY(OP_BUSY)) i_dp (
    .clk, .rst, .cke, .cmdPins({csN, rasN, casN, weN}), .ba, .apBit,
    .ocdField, .stb, .cmd, .ckePrev, .anyOpen, .busy, .ocdOn, .exitCnt,
    .errFlags
  );

  ckemon_ctrl #(.TXSNR(TXSNR), .TXSRD(TXSRD)) i_ctrl (
    .clk, .rst, .cke, .ckePrev, .cmd, .anyOpen, .busy, .ocdOn, .exitCnt,
    .stb, .pwrState(ps)
  );

  assign pwrState = ps;

endmodule

// File: rtl/ckemon_checker.sv
module ckemon_checker (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic [2:0] pwrState,
  input logic [5:0] errFlags
);

  logic ckeQ, started;
  logic refCmd;

  assign refCmd = !csN && !rasN && !casN && weN;

  always_ff @(posedge clk) begin
    if (rst) begin
      ckeQ    <= 1'b1;
      started <= 1'b0;
    end else begin
      ckeQ    <= cke;
      started <= 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (pwrState == 3'd0 && errFlags == 6'd0));

  assert_lowlow_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (started && !ckeQ && !cke && (pwrState inside {3'd2, 3'd3, 3'd4}))
      |=> pwrState == $past(pwrState));

  assert_sref_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (started && ckeQ && !cke && refCmd && (pwrState inside {3'd0, 3'd1}))
      |=> pwrState == 3'd4);

  assert_sref_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (started && pwrState == 3'd4 && cke) |=> pwrState == 3'd5);

  assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    started |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    started |-> pwrState <= 3'd5);

endmodule

bind cke_power_monitor ckemon_checker i_ckemon_checker (
  .clk, .rst, .cke, .csN, .rasN, .casN, .weN, .pwrState, .errFlags
);

// File: tb/test_cke_power_monitor.sv
module test_cke_power_monitor;

  localparam logic [3:0] NOP = 4'b0111, REF = 4'b0001, ACT = 4'b0011,
                         PRE = 4'b0010, RD  = 4'b0101, WR  = 4'b0100,
                         MRS = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, cke = 1'b1, apBit = 1'b0;
  logic [3:0] cmdPins = NOP;
  logic [1:0] ba = '0;
  logic [2:0] ocdField = '0;
  logic [2:0] pwrState;
  logic [5:0] errFlags;
  int checks = 0, failures = 0;

  cke_power_monitor i_cke_power_monitor (
    .clk, .rst, .cke, .csN(cmdPins[3]), .rasN(cmdPins[2]), .casN(cmdPins[1]),
    .weN(cmdPins[0]), .ba, .apBit, .ocdField, .pwrState, .errFlags
  );

  typedef struct packed {
    logic rst; logic cke; logic [3:0] cmd; logic [1:0] ba; logic ap;
    logic [2:0] ocd; logic [2:0] st; logic [5:0] er;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 0  R1 reset
    '{1'b0,1'b1,ACT,2'd1,1'b0,3'd0,3'd1,6'h00}, // 1  R4 activate
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd1,6'h00}, // 2
    '{1'b0,1'b0,NOP,2'd0,1'b0,3'd0,3'd3,6'h00}, // 3  R4 active power-down
    '{1'b0,1'b0,RD ,2'd0,1'b0,3'd0,3'd3,6'h00}, // 4  R2 ignored
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd1,6'h00}, // 5  R3 exit to active
    '{1'b0,1'b1,PRE,2'd1,1'b0,3'd0,3'd0,6'h00}, // 6  R4 precharge bank
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 7
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 8
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 9
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 10
    '{1'b0,1'b0,NOP,2'd0,1'b0,3'd0,3'd2,6'h00}, // 11 R7 busy just expired, R4 precharge PD
    '{1'b0,1'b0,NOP,2'd0,1'b0,3'd0,3'd2,6'h00}, // 12 R2
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 13 R3 exit to idle
    '{1'b1,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 14 R1
    '{1'b0,1'b1,ACT,2'd0,1'b0,3'd0,3'd1,6'h00}, // 15 R4
    '{1'b0,1'b1,ACT,2'd3,1'b0,3'd0,3'd1,6'h00}, // 16 R4
    '{1'b0,1'b1,PRE,2'd0,1'b0,3'd0,3'd1,6'h00}, // 17 R4 bank 3 still open
    '{1'b0,1'b1,PRE,2'd0,1'b1,3'd0,3'd0,6'h00}, // 18 R4 precharge all
    '{1'b0,1'b0,NOP,2'd0,1'b0,3'd0,3'd2,6'h04}, // 19 R7 entry while busy
    '{1'b0,1'b1,WR ,2'd0,1'b0,3'd0,3'd0,6'h06}, // 20 R6 exit with write, R12 bit 2 kept
    '{1'b1,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 21 R1 clears flags
    '{1'b0,1'b1,ACT,2'd2,1'b0,3'd0,3'd1,6'h00}, // 22
    '{1'b0,1'b0,REF,2'd0,1'b0,3'd0,3'd4,6'h04}, // 23 R7 self refresh with bank open
    '{1'b1,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 24
    '{1'b0,1'b1,MRS,2'd1,1'b0,3'd2,3'd0,6'h00}, // 25 R10 calibration on
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 26
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 27
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 28
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 29
    '{1'b0,1'b0,NOP,2'd0,1'b0,3'd0,3'd2,6'h20}, // 30 R10 CKE low in calibration
    '{1'b1,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 31
    '{1'b0,1'b1,NOP,2'd0,1'b0,3'd0,3'd0,6'h00}, // 32
    '{1'b0,1'b0,ACT,2'd0,1'b0,3'd0,3'd2,6'h02}  // 33 R6 entry with activate
  };

  task automatic check(input string tag, input logic [2:0] st, input logic [5:0] er);
    checks++;
    if (pwrState !== st || errFlags !== er) begin
      failures++;
      $display("FAIL %s: state=%0d expected %0d, errFlags=%h expected %h",
               tag, pwrState, st, errFlags, er);
    end
  endtask

  // inputs set away from the rising edge; returns after one edge
  task automatic step(input logic c, input logic [3:0] cm, input logic [1:0] b = 2'd0,
                      input logic ap = 1'b0, input logic [2:0] ocd = 3'd0);
    cke = c; cmdPins = cm; ba = b; apBit = ap; ocdField = ocd;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; step(1'b1, NOP); rst = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b1, NOP);
  endtask

  // reset, enter self refresh, leave it; ends after the exit edge (R5)
  task automatic enterExitSr();
    doReset();
    step(1'b0, REF);  check("R5 self refresh entry", 3'd4, 6'h00);
    step(1'b0, RD);   check("R2 command ignored in self refresh", 3'd4, 6'h00);
    step(1'b1, NOP);  check("R5 exit window", 3'd5, 6'h00);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rst = VECS[i].rst;
      step(VECS[i].cke, VECS[i].cmd, VECS[i].ba, VECS[i].ap, VECS[i].ocd);
      check($sformatf("table row %0d", i), VECS[i].st, VECS[i].er);
    end
    rst = 1'b0;

    // R8 boundary: activate just after the window is clean; R9 read at TXSRD legal
    enterExitSr();
    nops(16);
    step(1'b1, ACT, 2'd0);  check("R8 activate at edge TXSNR+1", 3'd5, 6'h00);
    nops(182);              check("R9 still in window at edge 199", 3'd5, 6'h00);
    step(1'b1, RD);         check("R9 read at edge TXSRD", 3'd1, 6'h00);

    // R8 violation at the last window edge
    enterExitSr();
    nops(15);
    step(1'b1, ACT, 2'd0);  check("R8 activate at edge TXSNR", 3'd5, 6'h08);

    // R8 and R9 on the same edge
    enterExitSr();
    nops(2);
    step(1'b1, RD);         check("R8 R9 early read", 3'd5, 6'h18);

    // R9 read one edge early, then window closes
    enterExitSr();
    nops(198);
    step(1'b1, RD);         check("R9 read at edge TXSRD-1", 3'd5, 6'h10);
    step(1'b1, NOP);        check("R9 window closes, R12 kept", 3'd0, 6'h10);

    // R11 clock-enable drop in the exit window
    enterExitSr();
    step(1'b0, NOP);        check("R11 CKE drop in exit window", 3'd2, 6'h01);

    // R6 self-refresh exit with a command
    doReset();
    step(1'b0, REF);
    step(1'b1, ACT, 2'd1);  check("R6 exit with activate", 3'd5, 6'h02);

    // R10 calibration switched off again: entry is clean
    doReset();
    step(1'b1, MRS, 2'd1, 1'b0, 3'd1);
    step(1'b1, MRS, 2'd1, 1'b0, 3'd0);
    nops(4);
    step(1'b0, NOP);        check("R10 calibration off", 3'd2, 6'h00);

    finishRun();
  end

endmodule